// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block turns two logic control lines into the four gate enables of a full bridge: a high-side and a low-side enable for each of two half-bridges (leg A and leg B). Each control line is first qualified, so short pulses are rejected. The qualified pair then selects one of four bridge states: forward drive, reverse drive, brake (both low-side switches on) or coast (all switches off). Every switch turns on only after both switches of its leg have been off for a programmable dead interval. Because of this, a leg can never short the supply, even when a pulse-width-modulated input toggles quickly between drive and brake.

The block also manages a low-power state. While the bridge is running, both qualified lines low for a programmable number of cycles puts the block to sleep. Reset also leaves it asleep. Waking needs sustained activity on either line, followed by a fixed delay during which all enables stay off. A kill input from the protection logic removes every enable in the same cycle. When kill is released, the outputs come back only through the dead interval. All timing constants are parameters counted in clock cycles.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is asserted, and directly after it, all four enables are low and `asleep` is high. The block does not wait for the sleep delay.
- R2: While running, the qualified pair selects the enables, written (ctl_a, ctl_b). (1,0) gives `hs_a` and `ls_b`. (0,1) gives `ls_a` and `hs_b`. (1,1) gives `ls_a` and `ls_b`. (0,0) gives no enable.
- R3: A switch turns on only after both switches of its leg have been off for at least DEAD_CYC consecutive cycles.
- R4: A switch that the new command no longer wants turns off at the first clock edge after the command changes, with no dead wait. This covers coast, brake and reversal.
- R5: A new level on a control line takes effect only after QUAL_CYC consecutive samples at that level. A pulse shorter than that leaves the enables and `asleep` unchanged.
- R6: While running, SLEEP_CYC consecutive cycles with both qualified lines low raise `asleep`. Any qualified high level restarts this count.
- R7: While asleep, qualified low inputs keep the block asleep. Waking needs qualified activity held for WAKE_QUAL_CYC further cycles; if the activity drops before then, the block stays asleep. `asleep` then falls, and all enables stay off for WAKE_DLY_CYC more cycles before drive starts.
- R8: While `kill` is high, all four enables are low in the same cycle. After `kill` falls, every switch comes back through the dead interval of R3.
- R9: The high-side and low-side enables of one leg are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_a | input | 1 | Control line for leg A (forward request) |
| ctl_b | input | 1 | Control line for leg B (reverse request) |
| kill | input | 1 | Global disable from the protection logic |
| hs_a | output | 1 | Leg A high-side gate enable |
| ls_a | output | 1 | Leg A low-side gate enable |
| hs_b | output | 1 | Leg B high-side gate enable |
| ls_b | output | 1 | Leg B low-side gate enable |
| asleep | output | 1 | High while sleeping or while qualifying a wake-up |

## Verification
A wrong power state shows at the ports within one cycle. Depending on the error, `asleep` takes the wrong level, or the first enable after a wake-up appears early or late against the count of QUAL_CYC, WAKE_QUAL_CYC and WAKE_DLY_CYC. A corrupted leg state or dead counter shows as an enable that rises with too short an off-gap before it, or as two enables of one leg high in the same cycle. Both are visible in the cycle of the turn-on. A broken qualifier lets a short pulse reach the enables QUAL_CYC cycles after the pulse began. For this reason, each cycle's sampled enables are compared with an independent cycle model, and the off-gap before every turn-on is measured.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        PWR_SLEEP = 2'd0,
        PWR_WAKEQ = 2'd1,
        PWR_WAKE  = 2'd2,
        PWR_RUN   = 2'd3
    } pwr_state_e;

    typedef enum logic [1:0] {
        LEG_FLOAT = 2'd0,
        LEG_HIGH  = 2'd1,
        LEG_LOW   = 2'd2
    } leg_cmd_e;

    // A leg drives high when only its own line is set, low whenever the
    // opposite line is set (reverse or brake), and floats otherwise.
    function automatic leg_cmd_e decode_leg(input logic own, input logic other);
        if (own && !other)
            return LEG_HIGH;
        else if (other)
            return LEG_LOW;
        else
            return LEG_FLOAT;
    endfunction

endpackage

// File: rtl/hbg_input_qual.sv
module hbg_input_qual #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (raw_i == cur_q.lvl) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == CW'(CYC - 1)) begin
            nxt_d.lvl = raw_i;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign lvl_o = cur_q.lvl;

    // R5
    qual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.lvl != $past(cur_q.lvl)) |-> ($past(raw_i) == cur_q.lvl));

endmodule

// File: rtl/hbg_power_fsm.sv
module hbg_power_fsm import hbg_pkg::*; #(
    parameter int SLEEP_CYC     = 1000,
    parameter int WAKE_QUAL_CYC = 50,
    parameter int WAKE_DLY_CYC  = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic run_o,
    output logic asleep_o
);
    localparam int MAX_AB = (SLEEP_CYC > WAKE_QUAL_CYC) ? SLEEP_CYC : WAKE_QUAL_CYC;
    localparam int MAXC   = (MAX_AB > WAKE_DLY_CYC) ? MAX_AB : WAKE_DLY_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [CW-1:0] cnt;
    } pwr_t;

    pwr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            PWR_SLEEP: begin
                nxt_d.cnt = '0;
                if (active_i)
                    nxt_d.st = PWR_WAKEQ;
            end
            PWR_WAKEQ: begin
                if (!active_i) begin
                    nxt_d.st  = PWR_SLEEP;
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == CW'(WAKE_QUAL_CYC - 1)) begin
                    nxt_d.st  = PWR_WAKE;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            PWR_WAKE: begin
                if (cur_q.cnt == CW'(WAKE_DLY_CYC - 1)) begin
                    nxt_d.st  = PWR_RUN;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            PWR_RUN: begin
                if (active_i) begin
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt == CW'(SLEEP_CYC - 1)) begin
                    nxt_d.st  = PWR_SLEEP;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + CW'(1);
                end
            end
            default: nxt_d = '{st: PWR_SLEEP, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '{st: PWR_SLEEP, cnt: '0};
        else
            cur_q <= nxt_d;
    end

    assign run_o    = (cur_q.st == PWR_RUN);
    assign asleep_o = (cur_q.st == PWR_SLEEP) || (cur_q.st == PWR_WAKEQ);

    // R7
    wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PWR_RUN && $past(cur_q.st) != PWR_RUN) |-> ($past(cur_q.st) == PWR_WAKE));

    // R6
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cur_q.st) == PWR_RUN && cur_q.st == PWR_SLEEP) |-> !$past(active_i));

endmodule

// File: rtl/hbg_half_seq.sv
module hbg_half_seq import hbg_pkg::*; #(
    parameter int DEAD_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_e cmd_i,
    output logic     hs_o,
    output logic     ls_o
);
    localparam int OW = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [OW-1:0] offc;
    } leg_t;

    leg_t cur_q, nxt_d;

    logic want_hs, want_ls, release_now, both_off;

    always_comb begin
        want_hs     = (cmd_i == LEG_HIGH);
        want_ls     = (cmd_i == LEG_LOW);
        release_now = (cmd_i == LEG_FLOAT) || (cur_q.hs && !want_hs) || (cur_q.ls && !want_ls);
        both_off    = !cur_q.hs && !cur_q.ls;

        nxt_d = cur_q;
        if (release_now) begin
            nxt_d.hs = 1'b0;
            nxt_d.ls = 1'b0;
        end else if (both_off && cur_q.offc >= OW'(DEAD_CYC)) begin
            nxt_d.hs = want_hs;
            nxt_d.ls = want_ls;
        end

        if (!nxt_d.hs && !nxt_d.ls)
            nxt_d.offc = (cur_q.offc == OW'(DEAD_CYC)) ? cur_q.offc : cur_q.offc + OW'(1);
        else
            nxt_d.offc = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign hs_o = cur_q.hs;
    assign ls_o = cur_q.ls;

    // R9
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_q.hs && cur_q.ls));

    // R3
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cur_q.hs) || $rose(cur_q.ls)) |-> $past(!cur_q.hs && !cur_q.ls));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == LEG_FLOAT) |=> (!cur_q.hs && !cur_q.ls));

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq import hbg_pkg::*; #(
    parameter int QUAL_CYC      = 80,
    parameter int DEAD_CYC      = 25,
    parameter int SLEEP_CYC     = 100000,
    parameter int WAKE_QUAL_CYC = 500,
    parameter int WAKE_DLY_CYC  = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_a,
    input  logic ctl_b,
    input  logic kill,
    output logic hs_a,
    output logic ls_a,
    output logic hs_b,
    output logic ls_b,
    output logic asleep
);
    localparam int NLEG = 2;

    logic [NLEG-1:0] raw_in;
    logic [NLEG-1:0] lvl;
    logic [NLEG-1:0] hs_q;
    logic [NLEG-1:0] ls_q;
    logic            run;
    leg_cmd_e        cmd [NLEG];

    assign raw_in = {ctl_b, ctl_a};

    for (genvar i = 0; i < NLEG; i++) begin : g_qual
        hbg_input_qual #(.CYC(QUAL_CYC)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_in[i]),
            .lvl_o (lvl[i])
        );
    end

    hbg_power_fsm #(
        .SLEEP_CYC     (SLEEP_CYC),
        .WAKE_QUAL_CYC (WAKE_QUAL_CYC),
        .WAKE_DLY_CYC  (WAKE_DLY_CYC)
    ) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (|lvl),
        .run_o    (run),
        .asleep_o (asleep)
    );

    always_comb begin
        for (int i = 0; i < NLEG; i++) begin
            if (run && !kill)
                cmd[i] = decode_leg(lvl[i], lvl[NLEG-1-i]);
            else
                cmd[i] = LEG_FLOAT;
        end
    end

    for (genvar i = 0; i < NLEG; i++) begin : g_leg
        hbg_half_seq #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd_i (cmd[i]),
            .hs_o  (hs_q[i]),
            .ls_o  (ls_q[i])
        );
    end

    assign hs_a = hs_q[0] & ~kill;
    assign ls_a = ls_q[0] & ~kill;
    assign hs_b = hs_q[1] & ~kill;
    assign ls_b = ls_q[1] & ~kill;

    // R7
    sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !(hs_q[0] || ls_q[0] || hs_q[1] || ls_q[1]));

    // R8
    kill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !(hs_q[0] || ls_q[0] || hs_q[1] || ls_q[1]));

endmodule

// File: tb/hbridge_gate_seq_test.sv
module hbridge_gate_seq_test;
    localparam int PER   = 10;
    localparam int QUAL  = 3;
    localparam int DEAD  = 4;
    localparam int SLP   = 40;
    localparam int WQ    = 6;
    localparam int WD    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_a = 1'b0, ctl_b = 1'b0, kill = 1'b0;
    logic hs_a, ls_a, hs_b, ls_b, asleep;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    hbridge_gate_seq #(
        .QUAL_CYC(QUAL), .DEAD_CYC(DEAD), .SLEEP_CYC(SLP),
        .WAKE_QUAL_CYC(WQ), .WAKE_DLY_CYC(WD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ctl_a(ctl_a), .ctl_b(ctl_b), .kill(kill),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .asleep(asleep)
    );

    // ---------------- reference model (from the requirements) ----------------
    // leg codes: 0 off, 1 high side on, 2 low side on
    function automatic int want_leg(input bit own, input bit other);
        if (own && !other) return 1;
        if (other) return 2;
        return 0;
    endfunction

    function automatic bit [4:0] expect_pins(input int on_a, input int on_b,
                                              input int pst, input bit k);
        bit [4:0] r;
        r[4] = (on_a == 1) && !k;
        r[3] = (on_a == 2) && !k;
        r[2] = (on_b == 1) && !k;
        r[1] = (on_b == 2) && !k;
        r[0] = (pst <= 1);
        return r;
    endfunction

    bit m_lvl [2] = '{0, 0};
    int m_run [2] = '{0, 0};
    int m_on  [2] = '{0, 0};
    int m_idle[2] = '{0, 0};
    int m_ps = 0;   // 0 sleep, 1 wake qualify, 2 wake delay, 3 running
    int m_pc = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_lvl[i] = 0; m_run[i] = 0; m_on[i] = 0; m_idle[i] = 0;
            end
            m_ps = 0; m_pc = 0;
        end else begin
            bit raw [2];
            bit act;
            raw[0] = ctl_a; raw[1] = ctl_b;
            for (int i = 0; i < 2; i++) begin
                int c;
                c = (m_ps == 3 && !kill) ? want_leg(m_lvl[i], m_lvl[1-i]) : 0;
                if (c == 0 || (m_on[i] != 0 && m_on[i] != c)) m_on[i] = 0;
                else if (m_on[i] == 0 && m_idle[i] >= DEAD) m_on[i] = c;
                m_idle[i] = (m_on[i] == 0) ? ((m_idle[i] + 1 > DEAD) ? DEAD : m_idle[i] + 1) : 0;
            end
            act = m_lvl[0] | m_lvl[1];
            case (m_ps)
                0: begin m_pc = 0; if (act) m_ps = 1; end
                1: begin
                    if (!act) begin m_ps = 0; m_pc = 0; end
                    else if (m_pc == WQ - 1) begin m_ps = 2; m_pc = 0; end
                    else m_pc++;
                end
                2: begin
                    if (m_pc == WD - 1) begin m_ps = 3; m_pc = 0; end
                    else m_pc++;
                end
                default: begin
                    if (act) m_pc = 0;
                    else if (m_pc == SLP - 1) begin m_ps = 0; m_pc = 0; end
                    else m_pc++;
                end
            endcase
            for (int i = 0; i < 2; i++) begin
                if (raw[i] == m_lvl[i]) m_run[i] = 0;
                else if (m_run[i] == QUAL - 1) begin m_lvl[i] = raw[i]; m_run[i] = 0; end
                else m_run[i]++;
            end
        end
    end

    // ---------------- per-cycle comparison and leg watchers ----------------
    int offgap [2] = '{0, 0};
    bit prev_on [2] = '{0, 0};

    always @(posedge clk) begin
        #(PER/4);
        if (rst_n && !done) begin
            bit [4:0] exp_v, act_v;
            bit on_now [2];
            exp_v = expect_pins(m_on[0], m_on[1], m_ps, kill);
            act_v = {hs_a, ls_a, hs_b, ls_b, asleep};
            checks++;
            if (act_v != exp_v) begin
                failures++;
                if (act_v[0] != exp_v[0])
                    $display("FAIL %s pins act=%b exp=%b", (m_ps == 3) ? "R6" : "R7", act_v, exp_v);
                else if (kill)
                    $display("FAIL R8 pins act=%b exp=%b", act_v, exp_v);
                else if (m_ps != 3)
                    $display("FAIL R7 pins act=%b exp=%b", act_v, exp_v);
                else
                    $display("FAIL R2 pins act=%b exp=%b", act_v, exp_v);
            end
            // R9: never both switches of one leg
            checks++;
            if ((hs_a && ls_a) || (hs_b && ls_b)) begin
                failures++;
                $display("FAIL R9 leg overlap act=%b exp=no overlap", act_v);
            end
            on_now[0] = hs_a | ls_a;
            on_now[1] = hs_b | ls_b;
            for (int i = 0; i < 2; i++) begin
                if (on_now[i] && !prev_on[i]) begin
                    // R3: measured off gap before each turn-on
                    checks++;
                    if (offgap[i] < DEAD) begin
                        failures++;
                        $display("FAIL R3 leg %0d off gap act=%0d exp>=%0d", i, offgap[i], DEAD);
                    end
                end
                offgap[i] = on_now[i] ? 0 : offgap[i] + 1;
                prev_on[i] = on_now[i];
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic set_in(input bit a, input bit b);
        @(negedge clk);
        ctl_a = a; ctl_b = b;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #(PER/4);
    endtask

    task automatic chk_pins(input string tag, input bit [4:0] exp_v);
        bit [4:0] act_v;
        act_v = {hs_a, ls_a, hs_b, ls_b, asleep};
        checks++;
        if (act_v != exp_v) begin
            failures++;
            $display("FAIL %s {hs_a,ls_a,hs_b,ls_b,asleep} act=%b exp=%b", tag, act_v, exp_v);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(PER * 200000);
        failures++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1;
        chk_pins("R1 in reset", 5'b00001);
        @(negedge clk);
        rst_n = 1'b1;
        wait_edges(1);
        chk_pins("R1 after reset", 5'b00001);
        wait_edges(60);
        chk_pins("R7 low inputs keep sleep", 5'b00001);

        // wake into forward drive
        set_in(1, 0);
        wait_edges(QUAL + WQ);
        chk_pins("R7 still qualifying", 5'b00001);
        wait_edges(1);
        chk_pins("R7 wake delay outputs off", 5'b00000);
        wait_edges(WD);
        chk_pins("R7 last wake cycle", 5'b00000);
        wait_edges(1);
        chk_pins("R2 forward", 5'b10010);

        // kill long, then release
        @(negedge clk); kill = 1'b1; #1;
        chk_pins("R8 same-cycle kill", 5'b00000);
        repeat (6) @(negedge clk);
        kill = 1'b0;
        wait_edges(1);
        chk_pins("R8 return after long kill", 5'b10010);
        // kill one cycle: re-entry through dead interval
        @(negedge clk); kill = 1'b1;
        @(negedge clk); kill = 1'b0;
        wait_edges(DEAD - 1);
        chk_pins("R8 dead after short kill", 5'b00000);
        wait_edges(1);
        chk_pins("R8 on after dead", 5'b10010);

        // reverse
        set_in(0, 1);
        wait_edges(QUAL);
        chk_pins("R5 before qualified", 5'b10010);
        wait_edges(1);
        chk_pins("R4 reversal releases", 5'b00000);
        wait_edges(DEAD - 1);
        chk_pins("R3 still dead", 5'b00000);
        wait_edges(1);
        chk_pins("R2 reverse", 5'b01100);

        // brake
        set_in(1, 1);
        wait_edges(QUAL + 1);
        chk_pins("R4 brake releases hs_b", 5'b01000);
        wait_edges(DEAD);
        chk_pins("R2 brake", 5'b01010);

        // short glitch on ctl_a
        set_in(0, 1);
        repeat (QUAL - 1) @(negedge clk);
        ctl_a = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wait_edges(1);
            chk_pins("R5 glitch ignored", 5'b01010);
        end

        // coast, then sleep entry
        set_in(0, 0);
        wait_edges(QUAL);
        chk_pins("R5 brake held until qualified", 5'b01010);
        wait_edges(1);
        chk_pins("R4 coast at once", 5'b00000);
        wait_edges(SLP - 2);
        chk_pins("R6 not yet asleep", 5'b00000);
        wait_edges(1);
        chk_pins("R6 asleep", 5'b00001);

        // aborted wake
        set_in(1, 0);
        repeat (QUAL + 2) @(negedge clk);
        ctl_a = 1'b0;
        for (int k = 0; k < 30; k++) begin
            wait_edges(1);
            chk_pins("R7 aborted wake stays asleep", 5'b00001);
        end

        // constrained random phase, checked cycle by cycle against the model
        for (int it = 0; it < 2500; it++) begin
            int r, hold;
            r = $urandom % 100;
            @(negedge clk);
            ctl_a = $urandom % 2;
            ctl_b = $urandom % 2;
            kill  = (($urandom % 20) == 0);
            hold  = (r < 60) ? 1 + ($urandom % 3) : 5 + ($urandom % 60);
            repeat (hold - 1) @(negedge clk);
            kill = 1'b0;
        end
        @(negedge clk); ctl_a = 1'b0; ctl_b = 1'b0; kill = 1'b0;
        wait_edges(QUAL + SLP + 5);
        chk_pins("R6 idle ends asleep", 5'b00001);
        finish_run();
    end

endmodule